// File: doc/BRIEF.md
# Two-Master Bus Ownership Arbiter

This block decides which of two masters drives a shared processor-local bus: a host CPU and one additional master. The CPU follows a hold / hold-acknowledge protocol. It owns the bus while its hold input is low. It gives the bus away by raising its acknowledge line, and while doing so it may raise a bus-request line to ask for the bus back. The additional master follows a request / grant protocol. It owns the bus while its grant is high, and it gives the bus back by dropping its request.

The arbiter rearbitrates when it samples the address strobe of the current owner. It does not wait for the end of the cycle. If the other party wants the bus at that moment, the arbiter signals preemption at once. The running cycle still completes. Ownership changes only after the owner has actually released the bus. When both parties keep asking, ownership alternates between them. A bus request that the CPU raises while it does not own the bus is held in a pending flag until the CPU regains the bus.

Top module: `dual_master_arb`

## Requirements
- R1: While reset is active and in the first cycle after it, `cpu_hold_o` is 0 and `xm_gnt_o` is 0, so the CPU owns the bus.
- R2: While the CPU owns the bus (`cpu_hold_o` = 0), a sampled `cpu_strobe_i` = 1 together with `xm_req_i` = 1 drives `cpu_hold_o` to 1 on the next cycle.
- R3: The owner is not preempted if the other party is not requesting when the owner's strobe is sampled. While the CPU owns the bus, `cpu_hold_o` stays 0 whenever `xm_req_i` is 0. While the extra master owns the bus, `xm_gnt_o` stays 1 on its strobe when the CPU has no pending or current bus request.
- R4: `xm_gnt_o` rises only on the cycle after `cpu_hlda_i` = 1 was sampled while `cpu_hold_o` was 1 and the extra master still requested.
- R5: While the extra master owns the bus, a sampled `xm_strobe_i` = 1 with a CPU request present drives `xm_gnt_o` to 0 on the next cycle, and `cpu_hold_o` stays 1.
- R6: Once `cpu_hold_o` = 1 and `xm_gnt_o` has been given, a sampled `xm_req_i` = 0 returns `cpu_hold_o` to 0 on the next cycle. This holds after preemption and after a voluntary release.
- R7: A `cpu_busreq_i` pulse sampled while the CPU does not own the bus is remembered as a CPU request until the bus is returned to the CPU.
- R8: `xm_gnt_o` is never 1 while `cpu_hlda_i` is 0, provided the CPU keeps `cpu_hlda_i` high while held.
- R9: `cpu_hold_o` is 1 whenever `xm_gnt_o` is 1.
- R10: If the extra master has withdrawn its request by the time `cpu_hlda_i` is sampled high, `cpu_hold_o` returns to 0 on the next cycle and `xm_gnt_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_hlda_i | input | 1 | CPU hold acknowledge; 1 means the CPU has released the bus |
| cpu_busreq_i | input | 1 | CPU request for the next ownership turn |
| cpu_strobe_i | input | 1 | CPU address strobe, start of a CPU cycle |
| xm_req_i | input | 1 | Extra master bus request; 0 releases the bus |
| xm_strobe_i | input | 1 | Extra master address strobe |
| cpu_hold_o | output | 1 | Hold request to the CPU |
| xm_gnt_o | output | 1 | Grant to the extra master |

## Verification
Two events can meet in one sampled cycle. The owner's strobe can arrive together with the other party's request changing, for example a CPU bus-request pulse on the same edge as the extra master's strobe. The CPU acknowledge can also arrive in the same cycle in which the extra master withdraws its request. Directed steps set up both coincidences: a bus-request pulse that falls before the master's strobe, and a request that is withdrawn before the acknowledge. The result is judged one cycle later against the expected hold and grant levels. A seeded random phase then drives every input with protocol-legal CPU acknowledge behaviour. In each cycle it compares both outputs with a reference model computed by bench functions.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    OWN_CPU   = 2'd0,
    YIELD_CPU = 2'd1,
    OWN_XM    = 2'd2,
    YIELD_XM  = 2'd3
  } own_e;
endpackage

// File: rtl/arb_pend.sv
module arb_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic busreq,
  input  logic cpu_owns,
  input  logic back_to_cpu,
  output logic cpu_want
);
  logic pend_q, pend_d, pend_en;

  always_comb begin
    pend_d  = back_to_cpu ? 1'b0 : (pend_q | (busreq & ~cpu_owns));
    pend_en = (pend_d != pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  // a request is present if remembered or raised this cycle
  assign cpu_want = pend_q | (busreq & ~cpu_owns);
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_hlda,
  input  logic cpu_strobe,
  input  logic cpu_want,
  input  logic xm_req,
  input  logic xm_strobe,
  output own_e st,
  output logic back_to_cpu
);
  own_e st_q, st_d;
  logic st_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      OWN_CPU:   if (cpu_strobe && xm_req) st_d = YIELD_CPU;
      YIELD_CPU: if (cpu_hlda)             st_d = xm_req ? OWN_XM : OWN_CPU;
      OWN_XM: begin
        if (!xm_req)                       st_d = OWN_CPU;
        else if (xm_strobe && cpu_want)    st_d = YIELD_XM;
      end
      YIELD_XM:  if (!xm_req)              st_d = OWN_CPU;
      default:                             st_d = OWN_CPU;
    endcase
    st_en       = (st_d != st_q);
    back_to_cpu = st_en && (st_d == OWN_CPU);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= OWN_CPU;
    else if (st_en) st_q <= st_d;
  end

  assign st = st_q;
endmodule

// File: rtl/arb_hs_out.sv
module arb_hs_out
  import arb_pkg::*;
(
  input  own_e st,
  output logic hold,
  output logic gnt,
  output logic cpu_owns
);
  always_comb begin
    cpu_owns = (st == OWN_CPU);
    hold     = ~cpu_owns;
    gnt      = (st == OWN_XM);
  end
endmodule

// File: rtl/dual_master_arb.sv
module dual_master_arb
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_hlda_i,
  input  logic cpu_busreq_i,
  input  logic cpu_strobe_i,
  input  logic xm_req_i,
  input  logic xm_strobe_i,
  output logic cpu_hold_o,
  output logic xm_gnt_o
);
  own_e st;
  logic cpu_owns, cpu_want, back_to_cpu;

  arb_pend u_pend (
    .clk(clk), .rst_n(rst_n), .busreq(cpu_busreq_i), .cpu_owns(cpu_owns),
    .back_to_cpu(back_to_cpu), .cpu_want(cpu_want)
  );

  arb_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cpu_hlda(cpu_hlda_i), .cpu_strobe(cpu_strobe_i),
    .cpu_want(cpu_want), .xm_req(xm_req_i), .xm_strobe(xm_strobe_i),
    .st(st), .back_to_cpu(back_to_cpu)
  );

  arb_hs_out u_out (
    .st(st), .hold(cpu_hold_o), .gnt(xm_gnt_o), .cpu_owns(cpu_owns)
  );
endmodule

// File: rtl/dual_master_arb_chk.sv
module dual_master_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_hlda_i,
  input logic cpu_busreq_i,
  input logic cpu_strobe_i,
  input logic xm_req_i,
  input logic xm_strobe_i,
  input logic cpu_hold_o,
  input logic xm_gnt_o
);
  AST_PREEMPT_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_hold_o && cpu_strobe_i && xm_req_i) |=> cpu_hold_o); // R2
  AST_NO_PREEMPT_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_hold_o && !xm_req_i) |=> !cpu_hold_o); // R3
  AST_GNT_AFTER_HLDA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xm_gnt_o) |-> $past(cpu_hlda_i && cpu_hold_o && xm_req_i)); // R4
  AST_PREEMPT_XM: assert property (@(posedge clk) disable iff (!rst_n)
    (xm_gnt_o && xm_req_i && xm_strobe_i && cpu_busreq_i) |=> (!xm_gnt_o && cpu_hold_o)); // R5
  AST_RETURN_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (xm_gnt_o && !xm_req_i) |=> !cpu_hold_o); // R6
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(xm_gnt_o && !cpu_hlda_i)); // R8
  AST_HOLD_WITH_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    xm_gnt_o |-> cpu_hold_o); // R9
endmodule

bind dual_master_arb dual_master_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_hlda_i(cpu_hlda_i), .cpu_busreq_i(cpu_busreq_i),
  .cpu_strobe_i(cpu_strobe_i), .xm_req_i(xm_req_i), .xm_strobe_i(xm_strobe_i),
  .cpu_hold_o(cpu_hold_o), .xm_gnt_o(xm_gnt_o)
);

// File: tb/dual_master_arb_test.sv
module dual_master_arb_test;
  logic clk, rst_n;
  logic hlda, breq, cstb, req, xstb;
  logic hold, gnt;
  int checks, errors;
  int ph;
  logic pend;

  dual_master_arb uut (
    .clk(clk), .rst_n(rst_n), .cpu_hlda_i(hlda), .cpu_busreq_i(breq),
    .cpu_strobe_i(cstb), .xm_req_i(req), .xm_strobe_i(xstb),
    .cpu_hold_o(hold), .xm_gnt_o(gnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // phases: 0 CPU owns, 1 CPU yielding, 2 master owns, 3 master yielding
  function automatic int next_ph(int p, logic pd, logic a_hlda, logic a_breq,
                                 logic a_cstb, logic a_req, logic a_xstb);
    logic want;
    want = pd | (a_breq && p != 0);
    case (p)
      0: return (a_cstb && a_req) ? 1 : 0;
      1: return a_hlda ? (a_req ? 2 : 0) : 1;
      2: return !a_req ? 0 : ((a_xstb && want) ? 3 : 2);
      default: return a_req ? 3 : 0;
    endcase
  endfunction

  function automatic logic next_pend(int p, int np, logic pd, logic a_breq);
    if (np == 0 && p != 0) return 1'b0;
    return pd | (a_breq && p != 0);
  endfunction

  task automatic expect_out(logic e_hold, logic e_gnt, string tag);
    checks++;
    if (hold !== e_hold || gnt !== e_gnt) begin
      errors++;
      $display("FAIL %s: hold=%b gnt=%b expected hold=%b gnt=%b", tag, hold, gnt, e_hold, e_gnt);
    end
  endtask

  task automatic tick(logic a_hlda, logic a_breq, logic a_cstb, logic a_req, logic a_xstb);
    int np;
    hlda = a_hlda; breq = a_breq; cstb = a_cstb; req = a_req; xstb = a_xstb;
    np   = next_ph(ph, pend, a_hlda, a_breq, a_cstb, a_req, a_xstb);
    pend = next_pend(ph, np, pend, a_breq);
    ph   = np;
    @(negedge clk);
    expect_out(ph != 0, ph == 2, "model R2/R3/R4/R5/R6/R7/R10");
    checks++;
    if (gnt && !hlda) begin
      errors++;
      $display("FAIL R8: gnt=%b hlda=%b expected no overlap", gnt, hlda);
    end
    checks++;
    if (gnt && !hold) begin
      errors++;
      $display("FAIL R9: hold=%b expected 1 while gnt=1", hold);
    end
  endtask

  initial begin
    checks = 0; errors = 0; ph = 0; pend = 1'b0;
    hlda = 0; breq = 0; cstb = 0; req = 0; xstb = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    expect_out(1'b0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    expect_out(1'b0, 1'b0, "R1 after reset");

    // handover sequence, both directions
    tick(0,0,1,0,0); expect_out(0,0,"R3 cpu strobe, no request");
    tick(0,0,0,1,0); expect_out(0,0,"R3 request without strobe");
    tick(0,0,1,1,0); expect_out(1,0,"R2 preempt cpu");
    tick(0,0,0,1,0); expect_out(1,0,"R4 no grant before hlda");
    tick(1,1,0,1,0); expect_out(1,1,"R4 grant after hlda");
    tick(1,0,0,1,0); expect_out(1,1,"R7 grant kept before strobe");
    tick(1,0,0,1,1); expect_out(1,0,"R5 R7 preempt master on stored busreq");
    tick(1,0,0,1,0); expect_out(1,0,"R5 hold kept until release");
    tick(1,0,0,0,0); expect_out(0,0,"R6 return after preempt");
    tick(0,0,0,0,0); expect_out(0,0,"R6 cpu keeps bus");
    // master not preempted without cpu request, then voluntary release
    tick(0,0,1,1,0); expect_out(1,0,"R2 preempt cpu again");
    tick(1,0,0,1,0); expect_out(1,1,"R4 grant again");
    tick(1,0,0,1,1); expect_out(1,1,"R3 master strobe, no cpu request");
    tick(1,0,0,0,0); expect_out(0,0,"R6 voluntary release");
    // request withdrawn before acknowledge
    tick(0,0,1,1,0); expect_out(1,0,"R2 preempt for withdraw case");
    tick(0,0,0,0,0); expect_out(1,0,"R10 hold kept while waiting hlda");
    tick(1,0,0,0,0); expect_out(0,0,"R10 hold drops, no grant");
    tick(0,0,0,0,0);

    // seeded random phase with protocol-legal hlda
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic n_hlda, n_req;
      if (ph != 0) n_hlda = hlda | (($urandom % 4) == 0);
      else         n_hlda = hlda & (($urandom % 2) == 0);
      n_req = (($urandom % 8) == 0) ? ~req : req;
      tick(n_hlda, ($urandom % 5) == 0, ($urandom % 3) == 0, n_req, ($urandom % 3) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule